// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns the short 7-bit offset carried by a direct-addressing instruction into a full 16-bit operand address. Data space is split into 512 pages of 128 words. In normal operation the upper nine bits come from a held data page register, so a single-word instruction can reach any word of the current page. When the compiler-mode bit is set, the offset is instead added to the stack pointer, which gives frame-relative access.

Two overrides sit on top of these modes. A register-access request pins the address into page 0, where the mapped registers and the scratch words live. A peripheral request takes its upper bits from a separate peripheral page register and marks the result as I/O space. The block holds the data page, peripheral page and compiler-mode registers and lets them be written. It registers its result one cycle after each request strobe.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset (asynchronous, active low), `valid_o`=0, `addr_o`=0 and `io_space_o`=0. The data page, the peripheral page and the compiler mode are all 0, so the first request after reset uses page concatenation with page 0.
- R2: With compiler mode 0 and neither override set, `addr_o` = {data page[8:0], offset[6:0]}, with the page in bits 15:7. For example, page 2 with offset 1 gives 0x0101.
- R3: With compiler mode 1 and neither override set, `addr_o` = stack pointer + offset, and the offset is treated as unsigned (zero-extended).
- R4: The stack-relative sum wraps modulo 2^16. For example, 0xFFF0 + 0x7F gives 0x006F.
- R5: With `mmr_i`=1 and `port_i`=0, `addr_o` = {9'b0, offset} and `io_space_o`=0, whatever the data page, stack pointer or compiler mode hold.
- R6: With `port_i`=1, `addr_o` = {peripheral page[8:0], offset[6:0]} and `io_space_o`=1. In every other case `io_space_o`=0.
- R7: When `port_i` and `mmr_i` are both 1, the peripheral form of R6 is used.
- R8: A register write issued in the same cycle as a request does not affect that request. It applies from the next request on.
- R9: For every cycle with `req_i`=1, the matching address and space tag appear on the outputs in the next cycle with `valid_o`=1. Requests in back-to-back cycles each produce their own result.
- R10: A cycle with `req_i`=0 is followed by a cycle with `valid_o`=0, and `addr_o` and `io_space_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request strobe |
| ofs_i | input | 7 | Offset field from the instruction |
| stk_ptr_i | input | 16 | Current stack pointer |
| mmr_i | input | 1 | Register-access request (forces page 0) |
| port_i | input | 1 | Peripheral-space request |
| dpage_wr_i | input | 1 | Write enable for the data page register |
| dpage_wdata_i | input | 9 | New data page value |
| ppage_wr_i | input | 1 | Write enable for the peripheral page register |
| ppage_wdata_i | input | 9 | New peripheral page value |
| cmode_wr_i | input | 1 | Write enable for the compiler-mode bit |
| cmode_wdata_i | input | 1 | New compiler-mode value |
| addr_o | output | 16 | Effective operand address |
| io_space_o | output | 1 | 1 = I/O space, 0 = data space |
| valid_o | output | 1 | Address valid strobe |

## Verification
Every result is due exactly one clock edge after its request. Register writes become visible to the request sampled at the edge after the write. The bench drives all inputs on the falling edge and samples the outputs on the following falling edge, after the single rising edge that registers the result. Same-cycle write-plus-request, back-to-back requests and idle cycles are each checked at that one-edge point, so a design with an extra or a missing register stage is caught.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
   typedef enum logic [1:0] {
      SRC_PAGE  = 2'd0,
      SRC_STACK = 2'd1,
      SRC_ZERO  = 2'd2,
      SRC_PORT  = 2'd3
   } addr_src_e;
endpackage

// File: rtl/pa_page_regs.sv
module pa_page_regs #(
   parameter int PAGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dpage_wr_i,
   input  logic [PAGE_W-1:0] dpage_wdata_i,
   input  logic              ppage_wr_i,
   input  logic [PAGE_W-1:0] ppage_wdata_i,
   input  logic              cmode_wr_i,
   input  logic              cmode_wdata_i,
   output logic [PAGE_W-1:0] dpage_q,
   output logic [PAGE_W-1:0] ppage_q,
   output logic              cmode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dpage_q <= '0;
         ppage_q <= '0;
         cmode_q <= 1'b0;
      end else begin
         if (dpage_wr_i) dpage_q <= dpage_wdata_i;
         if (ppage_wr_i) ppage_q <= ppage_wdata_i;
         if (cmode_wr_i) cmode_q <= cmode_wdata_i;
      end
   end
endmodule

// File: rtl/pa_addr_form.sv
module pa_addr_form
   import paged_addr_pkg::*;
#(
   parameter int OFS_W  = 7,
   parameter int PAGE_W = 9,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [PAGE_W-1:0] dpage_i,
   input  logic [PAGE_W-1:0] ppage_i,
   input  logic [ADDR_W-1:0] stk_ptr_i,
   input  logic              cmode_i,
   input  logic              mmr_i,
   input  logic              port_i,
   output logic [ADDR_W-1:0] addr_d,
   output logic              io_d
);
   addr_src_e         src;
   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] stk_sum;

   assign ofs_ext = {{PAGE_W{1'b0}}, ofs_i};
   assign stk_sum = stk_ptr_i + ofs_ext;

   always_comb begin
      if (port_i)       src = SRC_PORT;
      else if (mmr_i)   src = SRC_ZERO;
      else if (cmode_i) src = SRC_STACK;
      else              src = SRC_PAGE;
   end

   always_comb begin
      io_d = 1'b0;
      unique case (src)
         SRC_PAGE:  addr_d = {dpage_i, ofs_i};
         SRC_STACK: addr_d = stk_sum;
         SRC_ZERO:  addr_d = ofs_ext;
         SRC_PORT: begin
            addr_d = {ppage_i, ofs_i};
            io_d   = 1'b1;
         end
         default:   addr_d = '0;
      endcase
   end
endmodule

// File: rtl/pa_out_stage.sv
module pa_out_stage #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              io_d,
   output logic [ADDR_W-1:0] addr_o,
   output logic              io_space_o,
   output logic              valid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o     <= '0;
         io_space_o <= 1'b0;
         valid_o    <= 1'b0;
      end else begin
         valid_o <= req_i;
         if (req_i) begin
            addr_o     <= addr_d;
            io_space_o <= io_d;
         end
      end
   end
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen #(
   parameter int OFS_W  = 7,
   parameter int PAGE_W = 9,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [ADDR_W-1:0] stk_ptr_i,
   input  logic              mmr_i,
   input  logic              port_i,
   input  logic              dpage_wr_i,
   input  logic [PAGE_W-1:0] dpage_wdata_i,
   input  logic              ppage_wr_i,
   input  logic [PAGE_W-1:0] ppage_wdata_i,
   input  logic              cmode_wr_i,
   input  logic              cmode_wdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              io_space_o,
   output logic              valid_o
);
   generate
      if (OFS_W < 1 || PAGE_W < 1) begin : g_bad_width
         $error("paged_addr_gen: OFS_W and PAGE_W must be at least 1");
      end
   endgenerate

   logic [PAGE_W-1:0] dpage_q;
   logic [PAGE_W-1:0] ppage_q;
   logic              cmode_q;
   logic [ADDR_W-1:0] addr_d;
   logic              io_d;

   pa_page_regs #(.PAGE_W(PAGE_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .dpage_wr_i    (dpage_wr_i),
      .dpage_wdata_i (dpage_wdata_i),
      .ppage_wr_i    (ppage_wr_i),
      .ppage_wdata_i (ppage_wdata_i),
      .cmode_wr_i    (cmode_wr_i),
      .cmode_wdata_i (cmode_wdata_i),
      .dpage_q       (dpage_q),
      .ppage_q       (ppage_q),
      .cmode_q       (cmode_q)
   );

   pa_addr_form #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_form (
      .ofs_i     (ofs_i),
      .dpage_i   (dpage_q),
      .ppage_i   (ppage_q),
      .stk_ptr_i (stk_ptr_i),
      .cmode_i   (cmode_q),
      .mmr_i     (mmr_i),
      .port_i    (port_i),
      .addr_d    (addr_d),
      .io_d      (io_d)
   );

   pa_out_stage #(.ADDR_W(ADDR_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .addr_d     (addr_d),
      .io_d       (io_d),
      .addr_o     (addr_o),
      .io_space_o (io_space_o),
      .valid_o    (valid_o)
   );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
   parameter int OFS_W  = 7,
   parameter int PAGE_W = 9,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [OFS_W-1:0]  ofs_i,
   input logic [ADDR_W-1:0] stk_ptr_i,
   input logic              mmr_i,
   input logic              port_i,
   input logic              dpage_wr_i,
   input logic [PAGE_W-1:0] dpage_wdata_i,
   input logic              ppage_wr_i,
   input logic [PAGE_W-1:0] ppage_wdata_i,
   input logic              cmode_wr_i,
   input logic              cmode_wdata_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              io_space_o,
   input logic              valid_o
);
   logic [PAGE_W-1:0] dp_sh, pp_sh;
   logic              cm_sh;
   logic [ADDR_W-1:0] ofs_ext;
   assign ofs_ext = {{PAGE_W{1'b0}}, ofs_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_sh <= '0;
         pp_sh <= '0;
         cm_sh <= 1'b0;
      end else begin
         if (dpage_wr_i) dp_sh <= dpage_wdata_i;
         if (ppage_wr_i) pp_sh <= ppage_wdata_i;
         if (cmode_wr_i) cm_sh <= cmode_wdata_i;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !valid_o);

   assert_page_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !port_i && !mmr_i && !cm_sh) |=> addr_o == $past({dp_sh, ofs_i}));

   assert_stack_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !port_i && !mmr_i && cm_sh) |=> addr_o == $past(stk_ptr_i + ofs_ext));

   assert_zero_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && mmr_i && !port_i) |=> (addr_o[ADDR_W-1:OFS_W] == '0 && !io_space_o));

   assert_port_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && port_i) |=> (io_space_o && addr_o == $past({pp_sh, ofs_i})));

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> valid_o);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!valid_o && $stable(addr_o) && $stable(io_space_o)));
endmodule

bind paged_addr_gen pa_checker #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/sim_paged_addr_gen.sv
module sim_paged_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [6:0]  ofs_i = '0;
   logic [15:0] stk_ptr_i = '0;
   logic        mmr_i = 1'b0;
   logic        port_i = 1'b0;
   logic        dpage_wr_i = 1'b0;
   logic [8:0]  dpage_wdata_i = '0;
   logic        ppage_wr_i = 1'b0;
   logic [8:0]  ppage_wdata_i = '0;
   logic        cmode_wr_i = 1'b0;
   logic        cmode_wdata_i = 1'b0;
   logic [15:0] addr_o;
   logic        io_space_o;
   logic        valid_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   paged_addr_gen u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic [6:0] ofs, input logic [15:0] sp,
                         input logic mmr, input logic port);
      @(negedge clk);
      req_i = 1'b1; ofs_i = ofs; stk_ptr_i = sp; mmr_i = mmr; port_i = port;
      @(negedge clk);
      req_i = 1'b0; mmr_i = 1'b0; port_i = 1'b0;
   endtask

   task automatic wr_regs(input logic dw, input logic [8:0] dv, input logic pw,
                          input logic [8:0] pv, input logic cw, input logic cv);
      @(negedge clk);
      dpage_wr_i = dw; dpage_wdata_i = dv; ppage_wr_i = pw; ppage_wdata_i = pv;
      cmode_wr_i = cw; cmode_wdata_i = cv;
      @(negedge clk);
      dpage_wr_i = 1'b0; ppage_wr_i = 1'b0; cmode_wr_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 valid", valid_o, 0);
      chk("R1 addr", addr_o, 0);
      chk("R1 io", io_space_o, 0);
      do_req(7'h15, 16'h3000, 1'b0, 1'b0);
      chk("R1 first req uses page 0 mode 0", addr_o, 16'h0015);
   endtask

   task automatic t_page();
      wr_regs(1, 9'd2, 0, 0, 0, 0);
      do_req(7'h01, 16'h5555, 1'b0, 1'b0);
      chk("R2 page2 ofs1", addr_o, 16'h0101);
      chk("R2 io", io_space_o, 0);
      chk("R9 valid", valid_o, 1);
      wr_regs(1, 9'h1FF, 0, 0, 0, 0);
      do_req(7'h7F, 16'h0000, 1'b0, 1'b0);
      chk("R2 top page", addr_o, 16'hFFFF);
   endtask

   task automatic t_stack();
      wr_regs(0, 0, 0, 0, 1, 1);
      do_req(7'h10, 16'h1234, 1'b0, 1'b0);
      chk("R3 sp plus ofs", addr_o, 16'h1244);
      do_req(7'h7F, 16'h0081, 1'b0, 1'b0);
      chk("R3 carry into page bits", addr_o, 16'h0100);
      do_req(7'h7F, 16'hFFF0, 1'b0, 1'b0);
      chk("R4 wrap", addr_o, 16'h006F);
   endtask

   task automatic t_mmr();
      do_req(7'h65, 16'hABCD, 1'b1, 1'b0);
      chk("R5 mmr in mode1", addr_o, 16'h0065);
      chk("R5 io", io_space_o, 0);
      wr_regs(0, 0, 0, 0, 1, 0);
      do_req(7'h12, 16'hABCD, 1'b1, 1'b0);
      chk("R5 mmr in mode0 page 1FF", addr_o, 16'h0012);
   endtask

   task automatic t_port();
      wr_regs(0, 0, 1, 9'h0A5, 0, 0);
      do_req(7'h03, 16'h0000, 1'b0, 1'b1);
      chk("R6 port addr", addr_o, 16'h5283);
      chk("R6 io", io_space_o, 1);
      do_req(7'h04, 16'h0000, 1'b1, 1'b1);
      chk("R7 port over mmr addr", addr_o, 16'h5284);
      chk("R7 port over mmr io", io_space_o, 1);
      do_req(7'h04, 16'h0000, 1'b0, 1'b0);
      chk("R6 io back to data", io_space_o, 0);
   endtask

   task automatic t_same_cycle();
      wr_regs(1, 9'd2, 0, 0, 0, 0);
      @(negedge clk);
      dpage_wr_i = 1'b1; dpage_wdata_i = 9'd3;
      req_i = 1'b1; ofs_i = 7'h00;
      @(negedge clk);
      dpage_wr_i = 1'b0; req_i = 1'b0;
      chk("R8 old page used", addr_o, 16'h0100);
      do_req(7'h00, 16'h0000, 1'b0, 1'b0);
      chk("R8 new page next", addr_o, 16'h0180);
   endtask

   task automatic t_pipe_idle();
      @(negedge clk);
      req_i = 1'b1; ofs_i = 7'h05;
      @(negedge clk);
      ofs_i = 7'h06;
      chk("R9 first of pair", addr_o, 16'h0185);
      chk("R9 valid first", valid_o, 1);
      @(negedge clk);
      req_i = 1'b0;
      chk("R9 second of pair", addr_o, 16'h0186);
      chk("R9 valid second", valid_o, 1);
      ofs_i = 7'h7F; port_i = 1'b1;
      @(negedge clk);
      chk("R10 valid low", valid_o, 0);
      chk("R10 addr held", addr_o, 16'h0186);
      @(negedge clk);
      chk("R10 addr still held", addr_o, 16'h0186);
      chk("R10 io held", io_space_o, 0);
      port_i = 1'b0;
   endtask

   task automatic t_rerst();
      wr_regs(0, 0, 0, 0, 1, 1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 addr after reset", addr_o, 0);
      rst_n = 1'b1;
      do_req(7'h22, 16'h4000, 1'b0, 1'b0);
      chk("R1 mode cleared by reset", addr_o, 16'h0022);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset_pre();
   end

   task automatic t_reset_pre();
      chk("R1 valid in reset", valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_page();
      t_stack();
      t_mmr();
      t_port();
      t_same_cycle();
      t_pipe_idle();
      t_rerst();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask
endmodule